// File: doc/BRIEF.md
# Burst Column Order Generator

This block turns one column access request into the ordered list of column addresses that a DDR burst touches. A single-cycle `start` pulse presents a starting column, a raw 3-bit burst-length field and a burst-type bit. The block checks the field and latches the request. Starting on the next clock, it emits one full column address per cycle until the burst is over, together with a valid flag and a last-beat flag.

The burst never leaves an aligned block whose size equals the burst length. The column bits above that block keep the value of the starting column. Only the low offset walks through the block, in one of two orders. Sequential order counts upward and wraps. Interleaved order XORs the starting offset with the beat number. A new legal request that arrives mid-burst cuts the running burst short and starts over, which mirrors a read interrupting a read. A request with a reserved length code starts nothing and raises a one-cycle error flag.

Top module: `burst_col_gen`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `beat_valid`, `beat_last` and `code_err` are 0.
- R2: The length field `bl_code` maps 3'b001 to 2 beats, 3'b010 to 4 beats and 3'b011 to 8 beats. `bt_il` = 0 selects sequential order and `bt_il` = 1 selects interleaved order.
- R3: A legal `start` sampled on clock edge n makes `beat_valid` high from edge n+1 through edge n+BL, which is exactly BL consecutive cycles.
- R4: In sequential order, the low offset of beat k equals (s + k) mod BL, where s is the low log2(BL) bits of `start_col`.
- R5: In interleaved order, the low offset of beat k equals s XOR k.
- R6: On every beat, the bits of `beat_col` at and above bit log2(BL) equal the same bits of `start_col`.
- R7: `beat_last` is high only on beat BL-1. After that beat, `beat_valid` stays low until the next legal start.
- R8: A `start` with a reserved `bl_code` (000, 100, 101, 110 or 111) sets `code_err` high for exactly the cycle after it. It begins no burst, and a burst already running carries on unchanged.
- R9: A legal `start` during a running burst ends that burst. Beat 0 of the new burst appears on the next cycle.
- R10: While a burst is running and `start` is low, changes on `start_col`, `bl_code` and `bt_il` have no effect on the beats.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, one cycle |
| start_col | input | COL_W | Starting column address |
| bl_code | input | 3 | Raw burst-length field |
| bt_il | input | 1 | Burst type: 0 sequential, 1 interleaved |
| beat_valid | output | 1 | A beat address is present |
| beat_col | output | COL_W | Column address of the current beat |
| beat_last | output | 1 | Final beat of the burst |
| code_err | output | 1 | Reserved length code was requested |

## Verification
Sequential and interleaved bursts are run for all three lengths. The starting offsets are chosen so that the two orders produce different sequences: a non-zero start with length 8 separates the wrap from the XOR, and start 3 with length 4 does the same at the smaller size. A starting column with non-zero upper bits shows whether the block boundary and the held upper field are correct. Three further cases are covered: a legal request inside a burst, a reserved request inside a burst, and input changes during a burst. Together they separate restart, ignore and latch behaviour.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int OFF_W = 3;  // offset width for the longest burst (8)
  typedef enum logic { ORD_SEQ = 1'b0, ORD_XOR = 1'b1 } ord_e;
endpackage

// File: rtl/bl_decode.sv
module bl_decode
  import burst_pkg::*;
(
  input  logic [2:0]       code,
  output logic [OFF_W-1:0] mask,
  output logic             ok
);
  always_comb begin
    ok   = 1'b1;
    mask = '0;
    unique case (code)
      3'b001:  mask = 3'b001;
      3'b010:  mask = 3'b011;
      3'b011:  mask = 3'b111;
      default: ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/beat_ctr.sv
module beat_ctr
  import burst_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [OFF_W-1:0] load_mask,
  output logic             run_d,
  output logic [OFF_W-1:0] k_d,
  output logic [OFF_W-1:0] mask_d
);
  logic             run_q;
  logic [OFF_W-1:0] k_q, mask_q;

  always_comb begin
    run_d  = run_q;
    k_d    = k_q;
    mask_d = mask_q;
    if (load) begin
      run_d  = 1'b1;
      k_d    = '0;
      mask_d = load_mask;
    end else if (run_q) begin
      if (k_q == mask_q) run_d = 1'b0;
      else               k_d   = k_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      k_q    <= '0;
      mask_q <= '0;
    end else begin
      run_q  <= run_d;
      k_q    <= k_d;
      mask_q <= mask_d;
    end
  end
endmodule

// File: rtl/col_order.sv
module col_order
  import burst_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic [COL_W-1:0] base,
  input  logic [OFF_W-1:0] k,
  input  logic [OFF_W-1:0] mask,
  input  ord_e             ord,
  output logic [COL_W-1:0] col
);
  localparam int HI_W = COL_W - OFF_W;

  logic [OFF_W-1:0] s, raw, off;
  assign s   = base[OFF_W-1:0];
  assign raw = (ord == ORD_XOR) ? (s ^ k) : (s + k);

  // bits inside the block take the walked offset, bits above it keep the start
  for (genvar b = 0; b < OFF_W; b++) begin : g_bit
    assign off[b] = mask[b] ? raw[b] : s[b];
  end

  if (HI_W > 0) begin : g_hi
    assign col = {base[COL_W-1:OFF_W], off};
  end else begin : g_nohi
    assign col = off[COL_W-1:0];
  end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       bl_code,
  input  logic             bt_il,
  output logic             beat_valid,
  output logic [COL_W-1:0] beat_col,
  output logic             beat_last,
  output logic             code_err
);
  logic [OFF_W-1:0] dec_mask, k_d, mask_d;
  logic             dec_ok, load, run_d;
  logic [COL_W-1:0] base_q, base_d, col_d;
  ord_e             ord_q, ord_d;

  bl_decode u_dec (.code(bl_code), .mask(dec_mask), .ok(dec_ok));

  assign load = start && dec_ok;

  beat_ctr u_ctr (
    .clk(clk), .rst(rst), .load(load), .load_mask(dec_mask),
    .run_d(run_d), .k_d(k_d), .mask_d(mask_d)
  );

  assign base_d = load ? start_col : base_q;
  assign ord_d  = load ? ord_e'(bt_il) : ord_q;

  col_order #(.COL_W(COL_W)) u_ord (
    .base(base_d), .k(k_d), .mask(mask_d), .ord(ord_d), .col(col_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q     <= '0;
      ord_q      <= ORD_SEQ;
      beat_valid <= 1'b0;
      beat_col   <= '0;
      beat_last  <= 1'b0;
      code_err   <= 1'b0;
    end else begin
      base_q     <= base_d;
      ord_q      <= ord_d;
      beat_valid <= run_d;
      beat_col   <= col_d;
      beat_last  <= run_d && (k_d == mask_d);
      code_err   <= start && !dec_ok;
    end
  end
endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk #(
  parameter int COL_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic [2:0]       bl_code,
  input logic             beat_valid,
  input logic [COL_W-1:0] beat_col,
  input logic             beat_last,
  input logic             code_err
);
  logic good;
  assign good = (bl_code == 3'b001) || (bl_code == 3'b010) || (bl_code == 3'b011);

  p_good_start_r3: assert property (@(posedge clk) disable iff (rst)
    (start && good) |=> (beat_valid && !code_err));

  p_bad_flag_r8: assert property (@(posedge clk) disable iff (rst)
    (start && !good) |=> code_err);

  p_bad_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (start && !good && !beat_valid) |=> !beat_valid);

  p_last_valid_r7: assert property (@(posedge clk) disable iff (rst)
    beat_last |-> beat_valid);

  p_after_last_r7: assert property (@(posedge clk) disable iff (rst)
    (beat_last && !(start && good)) |=> !beat_valid);

  p_upper_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && $past(beat_valid) && !$past(start && good))
      |-> $stable(beat_col[COL_W-1:3]));
endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W)) chk_i (
  .clk(clk), .rst(rst), .start(start), .bl_code(bl_code),
  .beat_valid(beat_valid), .beat_col(beat_col),
  .beat_last(beat_last), .code_err(code_err)
);

// File: tb/burst_col_gen_tb_top.sv
module burst_col_gen_tb_top;
  localparam int COL_W = 10;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic [COL_W-1:0] start_col = '0;
  logic [2:0]       bl_code = 3'b001;
  logic             bt_il = 1'b0;
  logic             beat_valid, beat_last, code_err;
  logic [COL_W-1:0] beat_col;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  burst_col_gen #(.COL_W(COL_W)) dut_i (
    .clk(clk), .rst(rst), .start(start), .start_col(start_col),
    .bl_code(bl_code), .bt_il(bt_il), .beat_valid(beat_valid),
    .beat_col(beat_col), .beat_last(beat_last), .code_err(code_err)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_col(input int col, input int code, input int il, input int k);
    int bl   = 1 << code;
    int mask = bl - 1;
    int off  = il ? ((col ^ k) & mask) : ((col + k) & mask);
    return (col & ~mask) | off;
  endfunction

  // drive a start at a falling edge; return at the next falling edge with
  // beat 0 on the outputs; scramble the inputs afterwards (R10)
  task automatic issue(input int col, input int code, input int il);
    @(negedge clk);
    start = 1'b1; start_col = col[COL_W-1:0]; bl_code = code[2:0]; bt_il = il[0];
    @(negedge clk);
    start = 1'b0; start_col = ~start_col; bl_code = 3'b110; bt_il = ~bt_il;
  endtask

  task automatic expect_beat(input string req, input int col, input int code,
                             input int il, input int k);
    int bl = 1 << code;
    check({req, " valid"}, beat_valid, 1);
    check({req, " col"}, beat_col, exp_col(col, code, il, k));
    check({req, " last R7"}, beat_last, (k == bl - 1) ? 1 : 0);
  endtask

  task automatic run_beats(input string req, input int col, input int code,
                           input int il, input int from_k);
    int bl = 1 << code;
    for (int k = from_k; k < bl; k++) begin
      expect_beat(req, col, code, il, k);
      @(negedge clk);
    end
    check({req, " idle after last R7"}, beat_valid, 0);
  endtask

  task automatic t_reset;
    check("R1 valid", beat_valid, 0);
    check("R1 last", beat_last, 0);
    check("R1 err", code_err, 0);
  endtask

  task automatic t_sequential;
    issue(10'h1AD, 3, 0); run_beats("R4 R6 R2 seq8", 10'h1AD, 3, 0, 0);
    issue(10'h2F3, 2, 0); run_beats("R4 R6 seq4",   10'h2F3, 2, 0, 0);
    issue(10'h0C1, 1, 0); run_beats("R4 R3 seq2",   10'h0C1, 1, 0, 0);
  endtask

  task automatic t_interleaved;
    issue(10'h353, 3, 1); run_beats("R5 R6 R2 il8", 10'h353, 3, 1, 0);
    issue(10'h0F3, 2, 1); run_beats("R5 il4",       10'h0F3, 2, 1, 0);
    issue(10'h011, 1, 1); run_beats("R5 R3 il2",    10'h011, 1, 1, 0);
  endtask

  task automatic t_reserved;
    int codes[5] = '{0, 4, 5, 6, 7};
    foreach (codes[i]) begin
      issue(10'h055, codes[i], 0);
      check("R8 err set", code_err, 1);
      check("R8 no burst", beat_valid, 0);
      @(negedge clk);
      check("R8 err one cycle", code_err, 0);
      check("R8 still idle", beat_valid, 0);
    end
    // reserved request in the middle of a burst
    issue(10'h238, 3, 0);
    expect_beat("R8 run", 10'h238, 3, 0, 0);
    @(negedge clk);
    expect_beat("R8 run", 10'h238, 3, 0, 1);
    start = 1'b1; bl_code = 3'b101; start_col = 10'h3FF;
    @(negedge clk);
    start = 1'b0;
    check("R8 err mid-burst", code_err, 1);
    run_beats("R8 burst unchanged", 10'h238, 3, 0, 2);
  endtask

  task automatic t_interrupt;
    issue(10'h100, 3, 0);
    expect_beat("R9 first", 10'h100, 3, 0, 0);
    @(negedge clk);
    expect_beat("R9 first", 10'h100, 3, 0, 1);
    start = 1'b1; start_col = 10'h086; bl_code = 3'b010; bt_il = 1'b1;
    @(negedge clk);
    start = 1'b0; bl_code = 3'b011;
    run_beats("R9 restart", 10'h086, 2, 1, 0);
  endtask

  task automatic t_hold;
    // issue() scrambles every request input right after the start pulse
    issue(10'h3A6, 3, 1);
    run_beats("R10 inputs ignored", 10'h3A6, 3, 1, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 valid in reset", beat_valid, 0);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_sequential();
    t_interleaved();
    t_reserved();
    t_interrupt();
    t_hold();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule